// File: doc/BRIEF.md
# Three-Wire Control Register File

This block receives configuration words for a stereo audio converter over a write-only three-wire serial port: a data line, a shift clock and a latch strobe, qualified by an active-low select. Every serial line is sampled in the system clock domain through a synchronizer, and the edges of the shift clock and the latch strobe are detected there. Each complete 16-bit word is shifted in MSB first. A 3-bit address field in the word chooses one of five configuration registers. The register contents drive the rest of the converter as plain level outputs.

Two registers hold the left and right attenuation codes. Each channel has a staged value and a live value. A write stages a code. Only a write that carries the load bit copies the staged codes of both channels to the live outputs, so both channels can change in the same cycle. Two more registers hold mute, de-emphasis, forced-zero, word-length, format, polarity, filter, phase and zero-detect controls. A fifth register holds the differential output mode and the clock-loss detector disable. That register accepts writes only after a key pattern has been written into the mute/format control register.

Top module: `ctl3w_regfile`

## Requirements
- R1: On each rising edge of `cfg_sck` while `cfg_csn` is low, one bit of `cfg_sdi` is shifted in, first bit most significant. A rising edge of `cfg_latch` while `cfg_csn` is low commits the last 16 bits shifted in as one word.
- R2: Word bits 11:9 are the address. 000 and 001 select the left and right attenuation registers, 010 the control register, 011 the format register and 110 the extended register. Bits 15:12 have no effect. Words addressed to 100, 101 or 111 change nothing.
- R3: While `rst_n` is low, both staged codes and both live codes are 0xFF. Every other output is 0, and the extended register is locked.
- R4: A write to address 000 or 001 places bits 7:0 in that channel's staged code. When bit 8 of that word is 1, both live codes take the staged values, including the code carried by that word. When bit 8 is 0, the live codes are unchanged.
- R5: A write to address 010 sets `mute_req` from bit 0, `deemph_on` from bit 1, `force_zero` from bit 2 and `word_len_sel` from bits 4:3.
- R6: A write to address 011 sets `fmt_i2s` from bit 0, `wclk_invert` from bit 1, `att_common` from bit 2, `slow_rolloff` from bit 3, `phase_invert` from bit 4, `deemph_rate` from bits 7:6 and `zero_detect_en` from bit 8. Bit 5 is ignored.
- R7: A write to address 010 with bits 8:5 all 1 unlocks the extended register, and the unlock lasts until reset. Once unlocked, a write to 110 sets `diff_mode` from bits 5:4 and `clkloss_det_off` from bit 6. While locked, writes to 110 change nothing.
- R8: A word is discarded when `cfg_csn` is high during its shifting and latch, or when `dev_ready` is low at its latch.
- R9: A latch edge that follows any number of shifted bits other than 16 discards the word. Any latch edge, and `cfg_csn` high, restart the bit count.
- R10: With SYNC_STAGES synchronizer flops, outputs reflect a committed word SYNC_STAGES+1 clock edges after `cfg_latch` rises at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_ready | input | 1 | High when the device accepts writes |
| cfg_csn | input | 1 | Serial port select, active low |
| cfg_sck | input | 1 | Serial shift clock |
| cfg_sdi | input | 1 | Serial data, most significant bit first |
| cfg_latch | input | 1 | Rising edge commits the shifted word |
| att_left_staged | output | 8 | Staged left attenuation code |
| att_right_staged | output | 8 | Staged right attenuation code |
| att_left_live | output | 8 | Applied left attenuation code |
| att_right_live | output | 8 | Applied right attenuation code |
| mute_req | output | 1 | Soft mute request |
| deemph_on | output | 1 | De-emphasis enable |
| force_zero | output | 1 | Force converter output to zero |
| word_len_sel | output | 2 | Input word length select |
| fmt_i2s | output | 1 | I2S framing select |
| wclk_invert | output | 1 | Word clock polarity invert |
| att_common | output | 1 | Left code drives both channels |
| slow_rolloff | output | 1 | Slow filter roll-off select |
| phase_invert | output | 1 | Output phase reversal |
| deemph_rate | output | 2 | De-emphasis sample rate select |
| zero_detect_en | output | 1 | Zero-detect mute enable |
| diff_mode | output | 2 | Differential output mode |
| clkloss_det_off | output | 1 | Clock-loss detector disable |

## Verification
Attenuation is tried with staged-only writes followed by a load write on the other channel. This shows whether the load bit moves both channels or only the one addressed, and whether it uses the new code or a stale one. The control and format registers each receive two complementary bit patterns, which catches swapped or stuck field positions. The extended register is written while locked, after a near-miss key with only three of the four key bits set, after the full key, and again after the key bits are later cleared; this separates the lock gating from the sticky unlock. Finally, 15- and 17-bit words that carry otherwise valid payloads, writes with select high or ready low, and spare addresses with nonzero upper bits show that only exact, qualified 16-bit words reach the registers.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

  // Serial word geometry
  localparam int WORD_W   = 16;
  localparam int ATT_W    = 8;
  localparam int ADDR_W   = 3;
  localparam int ADDR_LSB = ATT_W + 1;          // address sits just above the load bit
  localparam int KEEP_W   = ADDR_LSB + ADDR_W;  // only the low bits of a word matter
  localparam int NCH      = 2;

  // Register select codes
  localparam logic [ADDR_W-1:0] SEL_ATT_L = 3'b000;
  localparam logic [ADDR_W-1:0] SEL_ATT_R = 3'b001;
  localparam logic [ADDR_W-1:0] SEL_CTRL  = 3'b010;
  localparam logic [ADDR_W-1:0] SEL_FMT   = 3'b011;
  localparam logic [ADDR_W-1:0] SEL_EXT   = 3'b110;

  typedef struct packed {
    logic       mute;
    logic       deemph;
    logic       fzero;
    logic [1:0] wlen;
  } ctrl_t;

  typedef struct packed {
    logic       i2s;
    logic       wpol;
    logic       common;
    logic       slow;
    logic       rev;
    logic [1:0] rate;
    logic       zdet;
  } fmt_t;

  typedef struct packed {
    logic [1:0] diff;
    logic       cld;
  } ext_t;

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift #(
  parameter int WORD_W = 16,
  parameter int KEEP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              lat,
  input  logic              csn,
  input  logic              ready,
  output logic              commit,
  output logic [KEEP_W-1:0] word
);

  // Counter must reach WORD_W and still have a distinct saturated value
  localparam int               CNT_W    = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;

  logic              sck_q, lat_q;
  logic              sck_rise, lat_rise;
  logic [CNT_W-1:0]  cnt;
  logic [KEEP_W-1:0] sh;

  assign sck_rise = sck & ~sck_q;
  assign lat_rise = lat & ~lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      lat_q <= 1'b0;
      cnt   <= '0;
      sh    <= '0;
    end else begin
      sck_q <= sck;
      lat_q <= lat;
      if (csn || lat_rise) begin
        cnt <= '0;
      end else if (sck_rise) begin
        // upper word bits fall off the top: they carry nothing
        sh <= {sh[KEEP_W-2:0], sdi};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end

  assign commit = lat_rise & ~csn & ready & (cnt == CNT_FULL);
  assign word   = sh;

endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
  import ctl3w_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic [KEEP_W-1:0]         word,
  output logic [NCH-1:0][ATT_W-1:0] att_stg,
  output logic [NCH-1:0][ATT_W-1:0] att_live,
  output ctrl_t                     ctrl,
  output fmt_t                      fmt,
  output ext_t                      ext,
  output logic                      ext_open
);

  logic [ADDR_W-1:0] addr;
  logic              load_bit;
  logic              att_sel;
  logic              load_wr;
  logic              key_hit;

  assign addr     = word[ADDR_LSB +: ADDR_W];
  assign load_bit = word[ATT_W];
  assign att_sel  = (addr < ADDR_W'(NCH));
  assign load_wr  = commit & att_sel & load_bit;
  assign key_hit  = &word[8:5];

  // One staged/live pair per channel; channel index equals its address
  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_chan
      logic             hit;
      logic [ATT_W-1:0] stg_q, live_q;

      assign hit = commit && (addr == ADDR_W'(ch));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q  <= '1;
          live_q <= '1;
        end else begin
          if (hit) stg_q <= word[ATT_W-1:0];
          if (load_wr) live_q <= hit ? word[ATT_W-1:0] : stg_q;
        end
      end

      assign att_stg[ch]  = stg_q;
      assign att_live[ch] = live_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      fmt      <= '0;
      ext      <= '0;
      ext_open <= 1'b0;
    end else if (commit) begin
      case (addr)
        SEL_CTRL: begin
          ctrl.mute   <= word[0];
          ctrl.deemph <= word[1];
          ctrl.fzero  <= word[2];
          ctrl.wlen   <= word[4:3];
          if (key_hit) ext_open <= 1'b1;
        end
        SEL_FMT: begin
          fmt.i2s    <= word[0];
          fmt.wpol   <= word[1];
          fmt.common <= word[2];
          fmt.slow   <= word[3];
          fmt.rev    <= word[4];
          fmt.rate   <= word[7:6];
          fmt.zdet   <= word[8];
        end
        SEL_EXT: begin
          if (ext_open) begin
            ext.diff <= word[5:4];
            ext.cld  <= word[6];
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile
  import ctl3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_ready,
  input  logic             cfg_csn,
  input  logic             cfg_sck,
  input  logic             cfg_sdi,
  input  logic             cfg_latch,
  output logic [ATT_W-1:0] att_left_staged,
  output logic [ATT_W-1:0] att_right_staged,
  output logic [ATT_W-1:0] att_left_live,
  output logic [ATT_W-1:0] att_right_live,
  output logic             mute_req,
  output logic             deemph_on,
  output logic             force_zero,
  output logic [1:0]       word_len_sel,
  output logic             fmt_i2s,
  output logic             wclk_invert,
  output logic             att_common,
  output logic             slow_rolloff,
  output logic             phase_invert,
  output logic [1:0]       deemph_rate,
  output logic             zero_detect_en,
  output logic [1:0]       diff_mode,
  output logic             clkloss_det_off
);

  logic                      csn_s, lat_s, sck_s, sdi_s;
  logic                      wr_commit;
  logic [KEEP_W-1:0]         wr_word;
  logic [NCH-1:0][ATT_W-1:0] att_stg, att_live;
  ctrl_t                     ctrl;
  fmt_t                      fmt;
  ext_t                      ext;
  logic                      ext_open;

  // select idles high so reset never looks like an active frame
  ctl3w_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cfg_csn, cfg_latch, cfg_sck, cfg_sdi}),
    .q     ({csn_s, lat_s, sck_s, sdi_s})
  );

  ctl3w_shift #(.WORD_W(WORD_W), .KEEP_W(KEEP_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck    (sck_s),
    .sdi    (sdi_s),
    .lat    (lat_s),
    .csn    (csn_s),
    .ready  (dev_ready),
    .commit (wr_commit),
    .word   (wr_word)
  );

  ctl3w_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (wr_commit),
    .word     (wr_word),
    .att_stg  (att_stg),
    .att_live (att_live),
    .ctrl     (ctrl),
    .fmt      (fmt),
    .ext      (ext),
    .ext_open (ext_open)
  );

  assign att_left_staged  = att_stg[0];
  assign att_right_staged = att_stg[1];
  assign att_left_live    = att_live[0];
  assign att_right_live   = att_live[1];

  assign mute_req     = ctrl.mute;
  assign deemph_on    = ctrl.deemph;
  assign force_zero   = ctrl.fzero;
  assign word_len_sel = ctrl.wlen;

  assign fmt_i2s        = fmt.i2s;
  assign wclk_invert    = fmt.wpol;
  assign att_common     = fmt.common;
  assign slow_rolloff   = fmt.slow;
  assign phase_invert   = fmt.rev;
  assign deemph_rate    = fmt.rate;
  assign zero_detect_en = fmt.zdet;

  assign diff_mode       = ext.diff;
  assign clkloss_det_off = ext.cld;

endmodule

// File: rtl/ctl3w_regfile_chk.sv
module ctl3w_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       commit,
  input logic [6:0] word_hi,   // word bits 11:5
  input logic       ext_open,
  input logic       csn_s,
  input logic       dev_ready,
  input logic [7:0] att_l_stg,
  input logic [7:0] att_r_stg,
  input logic [7:0] att_l_live,
  input logic [7:0] att_r_live,
  input logic       mute_req,
  input logic       fmt_i2s,
  input logic [1:0] diff_mode,
  input logic       clkloss_det_off
);

  logic [2:0] addr;
  logic       load_bit;
  logic       key_bits;

  assign addr     = word_hi[6:4];
  assign load_bit = word_hi[3];
  assign key_bits = &word_hi[3:0];

  // R3
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (att_l_stg == 8'hFF && att_r_stg == 8'hFF &&
                att_l_live == 8'hFF && att_r_live == 8'hFF &&
                !mute_req && !fmt_i2s && !ext_open));

  // R4
  live_l_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(att_l_live) |-> $past(commit && load_bit && addr[2:1] == 2'b00));

  // R4
  live_r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(att_r_live) |-> $past(commit && load_bit && addr[2:1] == 2'b00));

  // R4
  stg_l_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(att_l_stg) |-> $past(commit && addr == 3'b000));

  // R4
  stg_r_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(att_r_stg) |-> $past(commit && addr == 3'b001));

  // R5
  mute_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mute_req) |-> $past(commit && addr == 3'b010));

  // R6
  i2s_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fmt_i2s) |-> $past(commit && addr == 3'b011));

  // R7
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({diff_mode, clkloss_det_off}) |-> $past(commit && ext_open && addr == 3'b110));

  // R7
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_open) |-> $past(commit && addr == 3'b010 && key_bits));

  // R7
  unlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_open |=> ext_open);

  // R8
  commit_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (dev_ready && !csn_s));

endmodule

bind ctl3w_regfile ctl3w_regfile_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .commit          (wr_commit),
  .word_hi         (wr_word[11:5]),
  .ext_open        (ext_open),
  .csn_s           (csn_s),
  .dev_ready       (dev_ready),
  .att_l_stg       (att_left_staged),
  .att_r_stg       (att_right_staged),
  .att_l_live      (att_left_live),
  .att_r_live      (att_right_live),
  .mute_req        (mute_req),
  .fmt_i2s         (fmt_i2s),
  .diff_mode       (diff_mode),
  .clkloss_det_off (clkloss_det_off)
);

// File: tb/ctl3w_regfile_tb.sv
module ctl3w_regfile_tb;

  localparam int SYNC     = 2;
  localparam int LAT      = SYNC + 1;   // R10: edges from pin to output
  localparam int HALF     = 4;
  localparam int WD_LIMIT = 150000;
  localparam logic [47:0] RESET_VEC = {32'hFFFF_FFFF, 16'h0000};

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic dev_ready = 1'b0;
  logic cfg_csn = 1'b1, cfg_sck = 1'b0, cfg_sdi = 1'b0, cfg_latch = 1'b0;

  logic [7:0] att_left_staged, att_right_staged, att_left_live, att_right_live;
  logic       mute_req, deemph_on, force_zero;
  logic [1:0] word_len_sel;
  logic       fmt_i2s, wclk_invert, att_common, slow_rolloff, phase_invert;
  logic [1:0] deemph_rate;
  logic       zero_detect_en;
  logic [1:0] diff_mode;
  logic       clkloss_det_off;

  ctl3w_regfile #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_ready(dev_ready),
    .cfg_csn(cfg_csn), .cfg_sck(cfg_sck), .cfg_sdi(cfg_sdi), .cfg_latch(cfg_latch),
    .att_left_staged(att_left_staged), .att_right_staged(att_right_staged),
    .att_left_live(att_left_live), .att_right_live(att_right_live),
    .mute_req(mute_req), .deemph_on(deemph_on), .force_zero(force_zero),
    .word_len_sel(word_len_sel), .fmt_i2s(fmt_i2s), .wclk_invert(wclk_invert),
    .att_common(att_common), .slow_rolloff(slow_rolloff), .phase_invert(phase_invert),
    .deemph_rate(deemph_rate), .zero_detect_en(zero_detect_en),
    .diff_mode(diff_mode), .clkloss_det_off(clkloss_det_off)
  );

  always #5 clk = ~clk;

  // Behavioural reference state
  logic [7:0] m_stg_l = 8'hFF, m_stg_r = 8'hFF, m_live_l = 8'hFF, m_live_r = 8'hFF;
  logic m_mute = 0, m_deem = 0, m_fz = 0;
  logic [1:0] m_wl = 0;
  logic m_i2s = 0, m_pol = 0, m_com = 0, m_slow = 0, m_rev = 0, m_zd = 0;
  logic [1:0] m_rate = 0, m_diff = 0;
  logic m_cld = 0, m_open = 0;

  int    vectors = 0;
  int    miscompares = 0;
  int    cycles = 0;
  string cur_tag = "R3";
  logic  done = 1'b0;

  function automatic logic [47:0] model_vec();
    return {m_stg_l, m_stg_r, m_live_l, m_live_r,
            m_mute, m_deem, m_fz, m_wl,
            m_i2s, m_pol, m_com, m_slow, m_rev, m_rate, m_zd,
            m_diff, m_cld};
  endfunction

  logic [47:0] dut_vec;
  assign dut_vec = {att_left_staged, att_right_staged, att_left_live, att_right_live,
                    mute_req, deemph_on, force_zero, word_len_sel,
                    fmt_i2s, wclk_invert, att_common, slow_rolloff, phase_invert,
                    deemph_rate, zero_detect_en, diff_mode, clkloss_det_off};

  // Model output delayed by the pin-to-output latency
  logic [47:0] pipe [LAT] = '{default: RESET_VEC};

  always @(posedge clk) begin
    pipe[0] <= model_vec();
    for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
  end

  task automatic group_cmp(input string grp, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual %h expected %h", cur_tag, grp, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [47:0] e;
      e = pipe[LAT-1];
      vectors++;
      group_cmp("attenuation(R4)", dut_vec[47:16], e[47:16]);
      group_cmp("control(R5)", {27'd0, dut_vec[15:11]}, {27'd0, e[15:11]});
      group_cmp("format(R6)", {24'd0, dut_vec[10:3]}, {24'd0, e[10:3]});
      group_cmp("extended(R7)", {29'd0, dut_vec[2:0]}, {29'd0, e[2:0]});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_LIMIT && !done) begin
      miscompares++;
      $display("FAIL R10 watchdog: actual %0d cycles expected fewer than %0d", cycles, WD_LIMIT);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input logic [2:0] a, input logic [8:0] d);
    return {4'h0, a, d};
  endfunction

  task automatic model_apply(input logic [15:0] w);
    case (w[11:9])
      3'b000: begin
        m_stg_l = w[7:0];
        if (w[8]) begin m_live_l = m_stg_l; m_live_r = m_stg_r; end
      end
      3'b001: begin
        m_stg_r = w[7:0];
        if (w[8]) begin m_live_l = m_stg_l; m_live_r = m_stg_r; end
      end
      3'b010: begin
        m_mute = w[0]; m_deem = w[1]; m_fz = w[2]; m_wl = w[4:3];
        if (w[8:5] == 4'hF) m_open = 1'b1;
      end
      3'b011: begin
        m_i2s = w[0]; m_pol = w[1]; m_com = w[2]; m_slow = w[3];
        m_rev = w[4]; m_rate = w[7:6]; m_zd = w[8];
      end
      3'b110: begin
        if (m_open) begin m_diff = w[5:4]; m_cld = w[6]; end
      end
      default: ;
    endcase
  endtask

  // nbits above 16 prepend ones; below 16 drop the top bits
  task automatic send(input logic [15:0] w, input int nbits, input logic cs_level);
    cfg_csn = cs_level;
    idle(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      cfg_sdi = (i < 16) ? w[i] : 1'b1;
      idle(HALF);
      cfg_sck = 1'b1;
      idle(HALF);
      cfg_sck = 1'b0;
    end
    idle(HALF);
    cfg_latch = 1'b1;
    if (!cs_level && dev_ready && nbits == 16) model_apply(w);
    idle(HALF);
    cfg_latch = 1'b0;
    idle(HALF);
    cfg_csn = 1'b1;
    cfg_sdi = 1'b0;
    idle(HALF);
  endtask

  initial begin
    // R3: reset values
    #1 rst_n = 1'b0;
    idle(6);
    rst_n = 1'b1;
    dev_ready = 1'b1;
    idle(4);

    // R1: MSB-first word with load bit
    cur_tag = "R1";
    send(mk(3'b000, 9'h1A5), 16, 1'b0);

    // R4: staging and joint load
    cur_tag = "R4";
    send(mk(3'b000, 9'h040), 16, 1'b0);
    send(mk(3'b001, 9'h020), 16, 1'b0);
    send(mk(3'b001, 9'h120), 16, 1'b0);
    send(mk(3'b000, 9'h010), 16, 1'b0);
    send(mk(3'b001, 9'h033), 16, 1'b0);
    send(mk(3'b000, 9'h111), 16, 1'b0);

    // R5: control fields
    cur_tag = "R5";
    send(mk(3'b010, 9'h01B), 16, 1'b0);
    send(mk(3'b010, 9'h004), 16, 1'b0);

    // R6: format fields, bit 5 ignored
    cur_tag = "R6";
    send(mk(3'b011, 9'h1DF), 16, 1'b0);
    send(mk(3'b011, 9'h0A2), 16, 1'b0);
    send(mk(3'b011, 9'h020), 16, 1'b0);

    // R7: lock, near-miss key, full key, sticky unlock
    cur_tag = "R7";
    send(mk(3'b110, 9'h070), 16, 1'b0);
    send(mk(3'b010, 9'h0E0), 16, 1'b0);
    send(mk(3'b110, 9'h070), 16, 1'b0);
    send(mk(3'b010, 9'h1E0), 16, 1'b0);
    send(mk(3'b110, 9'h060), 16, 1'b0);
    send(mk(3'b010, 9'h003), 16, 1'b0);
    send(mk(3'b110, 9'h010), 16, 1'b0);

    // R2: upper bits ignored, spare addresses ignored
    cur_tag = "R2";
    send({4'hF, 3'b011, 9'h055}, 16, 1'b0);
    send(mk(3'b100, 9'h1FF), 16, 1'b0);
    send(mk(3'b101, 9'h1FF), 16, 1'b0);
    send(mk(3'b111, 9'h1FF), 16, 1'b0);

    // R8: select high, then not ready
    cur_tag = "R8";
    send(mk(3'b010, 9'h01F), 16, 1'b1);
    dev_ready = 1'b0;
    idle(4);
    send(mk(3'b011, 9'h1FF), 16, 1'b0);
    dev_ready = 1'b1;
    idle(4);

    // R9: short and long words
    cur_tag = "R9";
    send(mk(3'b000, 9'h1CC), 15, 1'b0);
    send(mk(3'b001, 9'h1DD), 17, 1'b0);

    // R10: back-to-back words after discards
    cur_tag = "R10";
    send(mk(3'b001, 9'h1AB), 16, 1'b0);
    send(mk(3'b010, 9'h018), 16, 1'b0);

    idle(10);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule